// File: doc/BRIEF.md
# Packed Integer Add/Subtract Unit

This unit performs one packed integer operation per clock on a pair of 128-bit source vectors and places the answer in an output register one clock later. The vector is cut into lanes of 8, 16, 32 or 64 bits, and the caller picks the lane width for each operation. Each lane is computed on its own. The available operations are wrapping add and subtract, negate, add or subtract of a small unsigned immediate, and saturating add and subtract in signed and unsigned forms. Two further operations ignore the lane width. They treat each source as a single 128-bit number built from a low and a high 64-bit half, and the carry or borrow passes from the low half into the high half.

A vector-enable input gates every issued operation. When it is low the result register is left untouched, the valid flag stays low, and a one-cycle fault flag is raised in its place. The surrounding pipeline drives `issue` for one cycle per operation. It takes the result when `res_valid` is high and raises an exception when `vec_fault` is high.

Top module: `simd_addsub`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` becomes zero and `res_valid` and `vec_fault` become low.
- R2: When `issue` and `vec_en` are both high at an edge, the next edge loads `result` with the answer and raises `res_valid` for one cycle. When `issue` is low, `res_valid` and `vec_fault` go low and `result` keeps its value.
- R3: Opcode 0 adds and opcode 1 subtracts (a minus b) in every lane with wrap-around. `lane_sz` 0, 1, 2 and 3 select 8, 16, 32 and 64-bit lanes, and no carry or borrow crosses a lane boundary.
- R4: Opcode 2 replaces each lane of `src_a` with zero minus that lane, so the most-negative lane value comes back unchanged.
- R5: Opcode 3 adds the 5-bit `imm`, taken as unsigned and zero-extended to the lane width, to every lane of `src_a` with wrap-around.
- R6: Opcode 4 adds the two's-complement negation of the zero-extended `imm` to every lane of `src_a`, which is the same as a wrapping subtract of `imm`.
- R7: Opcodes 5 (add) and 6 (subtract) saturate as signed values. On overflow a lane is clamped to its most-positive or most-negative value.
- R8: Opcodes 7 (add) and 8 (subtract) saturate as unsigned values. A lane clamps to all-ones when the add overflows and to zero when the subtract underflows.
- R9: Opcodes 9 (add) and 10 (subtract) work on the full 128 bits. The carry or borrow out of bits 63:0 enters bits 127:64, and `lane_sz` has no effect.
- R10: When `issue` is high and `vec_en` is low, the next edge leaves `result` unchanged, keeps `res_valid` low and raises `vec_fault` for one cycle.
- R11: Opcodes 11 to 15 load a zero result with `res_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| vec_en | input | 1 | Vector unit enabled; when low an issue faults |
| op | input | 4 | Operation code |
| lane_sz | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| imm | input | 5 | Unsigned immediate |
| result | output | 128 | Registered result |
| res_valid | output | 1 | Result was loaded at the last edge |
| vec_fault | output | 1 | Last issue was refused because the unit was disabled |

## Verification
Two effects can occur in the same cycle: a saturation clamp in one lane and a plain wrap or pass-through in the neighbouring lane, because each lane decides on its own. The byte sweep produces this on purpose. It pairs one fixed `src_a` byte with sixteen different `src_b` bytes, so some lanes overflow and clamp while others do not. The 128-bit carry across bit 64 sits next to the 64-bit lane add, which must not carry at that point. Both are driven with low halves of all-ones. Every lane of every result is compared against an arithmetic model that uses wide signed integers and then clamps or wraps.

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int VW   = 128,
  parameter int IMMW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          vec_en,
  input  logic [3:0]    op,
  input  logic [1:0]    lane_sz,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [IMMW-1:0] imm,
  output logic [VW-1:0] result,
  output logic          res_valid,
  output logic          vec_fault
);
  localparam int HALF = VW / 2;
  localparam logic [3:0] OP_ADD  = 4'd0, OP_SUB  = 4'd1, OP_NEG  = 4'd2,
                         OP_ADDI = 4'd3, OP_SUBI = 4'd4, OP_SADD = 4'd5,
                         OP_SSUB = 4'd6, OP_UADD = 4'd7, OP_USUB = 4'd8,
                         OP_ADDQ = 4'd9, OP_SUBQ = 4'd10;

  logic [VW-1:0] by_size [4];

  for (genvar g = 0; g < 4; g++) begin : gsz
    localparam int W = 8 << g;
    localparam int N = VW / W;
    for (genvar l = 0; l < N; l++) begin : gln
      logic [W-1:0] x, y, q;
      logic [W:0]   s;
      logic         sub, ov;
      always_comb begin
        x   = src_a[l*W +: W];
        y   = src_b[l*W +: W];
        sub = 1'b0;
        case (op)
          OP_SUB, OP_SSUB, OP_USUB: sub = 1'b1;
          OP_NEG: begin y = x; x = '0; sub = 1'b1; end
          OP_ADDI: y = W'(imm);
          OP_SUBI: y = -W'(imm);
          default: ;
        endcase
        s  = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
        ov = sub ? ((x[W-1] != y[W-1]) && (s[W-1] != x[W-1]))
                 : ((x[W-1] == y[W-1]) && (s[W-1] != x[W-1]));
        q  = s[W-1:0];
        case (op)
          OP_SADD, OP_SSUB:
            if (ov) q = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
          OP_UADD: if (s[W]) q = '1;
          OP_USUB: if (s[W]) q = '0;
          default: ;
        endcase
      end
      assign by_size[g][l*W +: W] = q;
    end
  end

  logic [HALF:0]   lo;
  logic [HALF-1:0] hi;
  logic            wsub;
  assign wsub = (op == OP_SUBQ);
  assign lo = wsub ? ({1'b0, src_a[HALF-1:0]} - {1'b0, src_b[HALF-1:0]})
                   : ({1'b0, src_a[HALF-1:0]} + {1'b0, src_b[HALF-1:0]});
  assign hi = wsub ? (src_a[VW-1:HALF] - src_b[VW-1:HALF] - HALF'(lo[HALF]))
                   : (src_a[VW-1:HALF] + src_b[VW-1:HALF] + HALF'(lo[HALF]));

  logic [VW-1:0] nxt;
  always_comb begin
    if (op == OP_ADDQ || op == OP_SUBQ) nxt = {hi, lo[HALF-1:0]};
    else if (op > OP_SUBQ)              nxt = '0;
    else                                nxt = by_size[lane_sz];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      res_valid <= 1'b0;
      vec_fault <= 1'b0;
    end else begin
      res_valid <= issue & vec_en;
      vec_fault <= issue & ~vec_en;
      if (issue && vec_en) result <= nxt;
    end
  end

  // R2
  issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && vec_en |=> res_valid && !vec_fault);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !res_valid && !vec_fault && $stable(result));
  // R10
  disabled_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !vec_en |=> vec_fault && !res_valid && $stable(result));
  // R9
  wide_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && vec_en && op == OP_ADDQ |=> result == $past(src_a) + $past(src_b));
  // R4
  neg64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && vec_en && op == OP_NEG && lane_sz == 2'd3
    |=> result[63:0] == 64'd0 - $past(src_a[63:0]));
  for (genvar l = 0; l < VW / 8; l++) begin : gua
    // R8
    usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue && vec_en && op == OP_UADD && lane_sz == 2'd0
      |=> result[l*8 +: 8] >= $past(src_a[l*8 +: 8]));
  end
endmodule

// File: tb/tb_simd_addsub.sv
module tb_simd_addsub;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue = 1'b0;
  logic         vec_en = 1'b1;
  logic [3:0]   op = '0;
  logic [1:0]   lane_sz = '0;
  logic [127:0] src_a = '0, src_b = '0;
  logic [4:0]   imm = '0;
  logic [127:0] result;
  logic         res_valid, vec_fault;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  simd_addsub dut (.clk(clk), .rst_n(rst_n), .issue(issue), .vec_en(vec_en),
    .op(op), .lane_sz(lane_sz), .src_a(src_a), .src_b(src_b), .imm(imm),
    .result(result), .res_valid(res_valid), .vec_fault(vec_fault));

  function automatic logic [127:0] model(input logic [3:0] o, input logic [1:0] ls,
      input logic [127:0] a, input logic [127:0] b, input logic [4:0] im);
    logic [127:0] out;
    int W;
    logic [63:0] m64;
    logic signed [65:0] full, half, ua, ub, sa, sb, r, ui;
    if (o == 4'd9)  return a + b;
    if (o == 4'd10) return a - b;
    if (o > 4'd10)  return '0;
    out = '0;
    W = 8 << ls;
    m64 = (W == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << W) - 64'd1);
    full = 66'sd1 <<< W;
    half = 66'sd1 <<< (W - 1);
    ui = {61'b0, im};
    for (int l = 0; l < 128 / W; l++) begin
      ua = {2'b0, 64'(a >> (l * W)) & m64};
      ub = {2'b0, 64'(b >> (l * W)) & m64};
      sa = (ua >= half) ? ua - full : ua;
      sb = (ub >= half) ? ub - full : ub;
      case (o)
        4'd0: r = ua + ub;
        4'd1: r = ua - ub;
        4'd2: r = -ua;
        4'd3: r = ua + ui;
        4'd4: r = ua - ui;
        4'd5, 4'd6: begin
          r = (o == 4'd5) ? sa + sb : sa - sb;
          if (r > half - 1) r = half - 1;
          if (r < -half)    r = -half;
        end
        default: begin
          r = (o == 4'd7) ? ua + ub : ua - ub;
          if (r > full - 1) r = full - 1;
          if (r < 0)        r = 0;
        end
      endcase
      out = out | (128'(r[63:0] & m64) << (l * W));
    end
    return out;
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:  return "R3";
      4'd2:        return "R4";
      4'd3:        return "R5";
      4'd4:        return "R6";
      4'd5, 4'd6:  return "R7";
      4'd7, 4'd8:  return "R8";
      4'd9, 4'd10: return "R9";
      default:     return "R11";
    endcase
  endfunction

  function automatic logic [63:0] corner(input int W);
    logic [63:0] m;
    m = (W == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << W) - 64'd1);
    case ($urandom % 8)
      0: return 64'd0;
      1: return 64'd1;
      2: return m >> 1;
      3: return (m >> 1) + 64'd1;
      4: return m;
      default: return {$urandom, $urandom} & m;
    endcase
  endfunction

  function automatic logic [127:0] vec_pat(input int W);
    logic [127:0] v;
    v = '0;
    for (int l = 0; l < 128 / W; l++) v = v | (128'(corner(W)) << (l * W));
    return v;
  endfunction

  task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] ls,
      input logic [127:0] a, input logic [127:0] b, input logic [4:0] im);
    issue = 1'b1; vec_en = 1'b1; op = o; lane_sz = ls;
    src_a = a; src_b = b; imm = im;
    @(negedge clk);
    check(req_of(o), result, model(o, ls, a, b, im));
    check("R2", {127'd0, res_valid}, 128'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", result, '0);
    check("R1", {126'd0, res_valid, vec_fault}, '0);
    rst_n = 1'b1;

    // R3 R7 R8: exhaustive byte pairs, imm sweeps along
    for (int o = 0; o <= 8; o++)
      for (int i = 0; i < 256; i++)
        for (int jb = 0; jb < 16; jb++) begin
          logic [127:0] bv;
          for (int l = 0; l < 16; l++) bv[l*8 +: 8] = 8'(jb * 16 + l);
          run(4'(o), 2'd0, {16{8'(i)}}, bv, 5'(i));
        end

    // wider lanes with corner-heavy operands
    for (int ls = 1; ls < 4; ls++)
      for (int o = 0; o <= 8; o++)
        for (int k = 0; k < 300; k++)
          run(4'(o), 2'(ls), vec_pat(8 << ls), vec_pat(8 << ls), 5'($urandom));

    // R5 R6 full immediate sweep
    for (int ls = 0; ls < 4; ls++)
      for (int o = 3; o <= 4; o++)
        for (int im = 0; im < 32; im++)
          for (int k = 0; k < 4; k++)
            run(4'(o), 2'(ls), vec_pat(8 << ls), '0, 5'(im));

    // R4 most-negative lanes wrap to themselves
    run(4'd2, 2'd0, {16{8'h80}}, '0, '0);
    run(4'd2, 2'd3, {2{64'h8000_0000_0000_0000}}, '0, '0);

    // R9 carry and borrow across bit 64, lane size ignored
    run(4'd9, 2'd0, {64'd5, 64'hFFFF_FFFF_FFFF_FFFF}, 128'd1, '0);
    run(4'd10, 2'd3, {64'd5, 64'd0}, 128'd1, '0);
    run(4'd0, 2'd3, {64'd5, 64'hFFFF_FFFF_FFFF_FFFF}, 128'd1, '0);
    for (int k = 0; k < 500; k++)
      run(4'(9 + (k % 2)), 2'($urandom), vec_pat(64), vec_pat(64), '0);

    // R11 undefined opcodes
    for (int o = 11; o < 16; o++) run(4'(o), 2'd1, '1, '1, 5'd7);

    // R10 disabled issue
    run(4'd0, 2'd0, {16{8'h11}}, {16{8'h22}}, '0);
    held = result;
    issue = 1'b1; vec_en = 1'b0; op = 4'd1; src_a = '1; src_b = '0;
    @(negedge clk);
    check("R10", result, held);
    check("R10", {126'd0, res_valid, vec_fault}, 128'd1);

    // R2 idle holds result
    issue = 1'b0; vec_en = 1'b1; src_a = '0;
    @(negedge clk);
    check("R2", result, held);
    check("R2", {126'd0, res_valid, vec_fault}, '0);

    // R1 reset mid-run
    run(4'd0, 2'd0, {16{8'h01}}, {16{8'h01}}, '0);
    issue = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    check("R1", result, '0);
    check("R1", {126'd0, res_valid, vec_fault}, '0);
    issue = 1'b0; rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule